// File: doc/BRIEF.md
# Target-to-Host Command Mailbox

The block gives a target processor a small four-word mailbox for talking to a host. It holds two 64-bit registers. The outbound register carries requests from the target. The return register carries replies back to it. Software reaches each register through two 32-bit words on a simple word-indexed write and read port. Reads are combinational.

A store to the upper word of the outbound register is the doorbell. In that cycle the block classifies the complete 64-bit value: the upper word just written, joined with the lower word already held. The top byte names a device and the byte below it names a command. A value of exactly one asks for power-off. Device 1 with command 1 sends the lowest byte to a console and writes an acknowledgement into the return register. Device 1 with command 0 clears the outbound register. Anything else is left in place and raises a sticky error flag.

Top module: `hostlink_mbox`

## Requirements
- R1: After reset, all four words read as zero, and `off_pulse`, `cons_valid` and `unsup_err` are low.
- R2: Word index 0 holds outbound bits 31:0, index 1 outbound bits 63:32, index 2 return bits 31:0 and index 3 return bits 63:32. A write to any index stores its data there, unless R6 or R7 overrides it, and the stored value can be read back at the same index.
- R3: A write to index 0 changes only the outbound low word. It never starts a command and produces no pulse.
- R4: Only a write to index 1 starts a command. The command is decoded from the merged value {written data, held low word}, with the device number in bits 63:56 and the command number in bits 55:48.
- R5: If the merged value equals exactly 1, `off_pulse` is high for the one cycle after the write edge. Both registers keep their written contents.
- R6: If the device is 1 and the command is 1, `cons_valid` is high for the one cycle after the write edge, and `cons_byte` equals bits 7:0 of the merged value. The outbound register becomes zero and the return register becomes 0x0101_0000_0000_0000.
- R7: If the device is 1 and the command is 0, the outbound register becomes zero. The return register is unchanged and no pulse is produced.
- R8: Any other value written through index 1 is stored unchanged and sets `unsup_err`. The flag stays set until reset.
- R9: `off_pulse` and `cons_valid` are never high together. Each one is high only in the cycle after a write to index 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_word | input | 2 | Word index (byte offset divided by four) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_word`, combinational |
| off_pulse | output | 1 | One-cycle power-off request |
| cons_valid | output | 1 | One-cycle console byte strobe |
| cons_byte | output | 8 | Console byte, valid while `cons_valid` is high |
| unsup_err | output | 1 | Sticky unsupported-command flag |

## Verification
The assertions assume that `bus_we`, `bus_word` and `bus_wdata` are known in every cycle after reset, and that at most one word is written per cycle. The checks look back one cycle with `$past` to find which write caused a pulse.

The bench drives all inputs from tasks at the falling edge, and holds `bus_we` low during reset and between operations. It draws each random word index and command byte from a small set around devices 0, 1, 2 and 255. This set makes every decode branch appear often, including the exact-one value built from a low-word write followed by a zero upper word.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned REG_W   = 2 * WORD_W;
  localparam int unsigned FIELD_W = 8;
  localparam int unsigned DEV_LSB = REG_W - FIELD_W;
  localparam int unsigned CMD_LSB = REG_W - 2 * FIELD_W;
  localparam int unsigned NWORDS  = 4;

  localparam logic [FIELD_W-1:0] DEV_CONSOLE = 8'd1;
  localparam logic [FIELD_W-1:0] CMD_PUTC    = 8'd1;
  localparam logic [FIELD_W-1:0] CMD_DROP    = 8'd0;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_OFF,
    ACT_PUTC,
    ACT_DROP,
    ACT_BAD
  } act_e;

  typedef enum logic [1:0] {
    SEL_OUT_LO = 2'd0,
    SEL_OUT_HI = 2'd1,
    SEL_RET_LO = 2'd2,
    SEL_RET_HI = 2'd3
  } sel_e;
endpackage

// File: rtl/hostlink_decode.sv
module hostlink_decode
  import hostlink_pkg::*;
#(
  parameter int unsigned RW = REG_W
) (
  input  logic          trig,
  input  logic [RW-1:0] value,
  output act_e          act
);
  localparam int unsigned DL = RW - FIELD_W;
  localparam int unsigned CL = RW - 2 * FIELD_W;

  logic [FIELD_W-1:0] dev;
  logic [FIELD_W-1:0] cmd;

  assign dev = value[DL +: FIELD_W];
  assign cmd = value[CL +: FIELD_W];

  // Priority order: exact-one, console put, console drop, then everything else.
  always_comb begin
    act = ACT_NONE;
    if (trig) begin
      if (value == RW'(1))
        act = ACT_OFF;
      else if (dev == DEV_CONSOLE && cmd == CMD_PUTC)
        act = ACT_PUTC;
      else if (dev == DEV_CONSOLE && cmd == CMD_DROP)
        act = ACT_DROP;
      else
        act = ACT_BAD;
    end
  end
endmodule

// File: rtl/hostlink_regs.sv
module hostlink_regs
  import hostlink_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_sel,
  input  logic [W-1:0]   wr_data,
  input  act_e           act,
  input  logic [1:0]     rd_sel,
  output logic [W-1:0]   rd_data,
  output logic [W-1:0]   out_lo
);
  localparam int unsigned RW = 2 * W;
  localparam logic [RW-1:0] ACK_VAL =
    {DEV_CONSOLE, CMD_PUTC, {(RW - 2 * FIELD_W){1'b0}}};

  logic [W-1:0] word_q [NWORDS];
  logic [W-1:0] word_d [NWORDS];
  logic         word_en[NWORDS];

  genvar gi;
  generate
    for (gi = 0; gi < NWORDS; gi++) begin : g_word
      localparam bit IS_OUT = (gi < 2);
      localparam int unsigned HALF = gi % 2;

      always_comb begin
        word_d[gi]  = word_q[gi];
        word_en[gi] = 1'b0;
        if (wr_en && wr_sel == 2'(gi)) begin
          word_d[gi]  = wr_data;
          word_en[gi] = 1'b1;
        end
        if (IS_OUT && (act == ACT_PUTC || act == ACT_DROP)) begin
          word_d[gi]  = '0;
          word_en[gi] = 1'b1;
        end
        if (!IS_OUT && act == ACT_PUTC) begin
          word_d[gi]  = ACK_VAL[HALF*W +: W];
          word_en[gi] = 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          word_q[gi] <= '0;
        else if (word_en[gi])
          word_q[gi] <= word_d[gi];
      end
    end
  endgenerate

  assign rd_data = word_q[rd_sel];
  assign out_lo  = word_q[0];
endmodule

// File: rtl/hostlink_mbox.sv
module hostlink_mbox
  import hostlink_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_word,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              off_pulse,
  output logic              cons_valid,
  output logic [7:0]        cons_byte,
  output logic              unsup_err
);
  localparam int unsigned RW = 2 * DATA_W;

  logic [DATA_W-1:0] out_lo;
  logic [RW-1:0]     merged;
  logic              trig;
  act_e              act;

  logic       off_d, putc_d, err_d;
  logic [7:0] byte_d;
  logic       off_q, putc_q, err_q;
  logic [7:0] byte_q;

  assign trig   = bus_we && (bus_word == SEL_OUT_HI);
  assign merged = {bus_wdata, out_lo};

  hostlink_decode #(.RW(RW)) u_dec (
    .trig  (trig),
    .value (merged),
    .act   (act)
  );

  hostlink_regs #(.W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_we),
    .wr_sel  (bus_word),
    .wr_data (bus_wdata),
    .act     (act),
    .rd_sel  (bus_word),
    .rd_data (bus_rdata),
    .out_lo  (out_lo)
  );

  always_comb begin
    off_d  = (act == ACT_OFF);
    putc_d = (act == ACT_PUTC);
    err_d  = err_q | (act == ACT_BAD);
    byte_d = putc_d ? merged[7:0] : byte_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= 1'b0;
      putc_q <= 1'b0;
      err_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      off_q  <= off_d;
      putc_q <= putc_d;
      err_q  <= err_d;
      byte_q <= byte_d;
    end
  end

  assign off_pulse  = off_q;
  assign cons_valid = putc_q;
  assign cons_byte  = byte_q;
  assign unsup_err  = err_q;
endmodule

// File: rtl/hostlink_chk.sv
module hostlink_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [1:0]        bus_word,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              off_pulse,
  input logic              cons_valid,
  input logic [7:0]        cons_byte,
  input logic              unsup_err
);
  // R9: the two strobes never coincide
  p_excl_pulses_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({off_pulse, cons_valid}));

  // R4, R5: power-off only follows an upper-word write
  p_off_after_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    off_pulse |-> $past(bus_we && bus_word == 2'd1));

  // R5: the upper word of an exact-one value is zero
  p_off_hi_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    off_pulse |-> $past(bus_wdata) == '0);

  // R6: console strobe follows an upper-word write naming device 1, command 1
  p_putc_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cons_valid |-> $past(bus_we && bus_word == 2'd1 &&
                         bus_wdata[DATA_W-1 -: 16] == 16'h0101));

  // R3: a low-word write never produces a pulse
  p_lo_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_word == 2'd0) |=> !(off_pulse || cons_valid));

  // R8: error flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_err |=> unsup_err);

  // R8: error rises only after an upper-word write
  p_err_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unsup_err) |-> $past(bus_we && bus_word == 2'd1));
endmodule

bind hostlink_mbox hostlink_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_hostlink_mbox.sv
`timescale 1ns/1ps
module sim_hostlink_mbox;
  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [1:0]  bus_word;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        off_pulse;
  logic        cons_valid;
  logic [7:0]  cons_byte;
  logic        unsup_err;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  logic [63:0] m_out;
  logic [63:0] m_ret;
  bit          m_err;

  hostlink_mbox u0 (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_all(input string req);
    bus_we = 1'b0;
    for (int i = 0; i < 4; i++) begin
      bus_word = 2'(i);
      #1;
      case (i)
        0: chk(req, 64'(bus_rdata), 64'(m_out[31:0]));
        1: chk(req, 64'(bus_rdata), 64'(m_out[63:32]));
        2: chk(req, 64'(bus_rdata), 64'(m_ret[31:0]));
        default: chk(req, 64'(bus_rdata), 64'(m_ret[63:32]));
      endcase
    end
  endtask

  // Expected behaviour from R2..R8
  task automatic wr(input logic [1:0] w, input logic [31:0] d);
    logic [63:0] v;
    bit e_off, e_putc;
    logic [7:0] e_byte;
    e_off = 0; e_putc = 0; e_byte = 8'h0;
    case (w)
      2'd0: m_out[31:0]  = d;
      2'd2: m_ret[31:0]  = d;
      2'd3: m_ret[63:32] = d;
      default: begin
        v = {d, m_out[31:0]};
        m_out = v;
        if (v == 64'd1) e_off = 1;
        else if (v[63:48] == 16'h0101) begin
          e_putc = 1; e_byte = v[7:0];
          m_out = '0; m_ret = 64'h0101_0000_0000_0000;
        end else if (v[63:48] == 16'h0100) m_out = '0;
        else m_err = 1;
      end
    endcase
    @(negedge clk);
    bus_we = 1'b1; bus_word = w; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    chk("R5 off_pulse", 64'(off_pulse), 64'(e_off));
    chk("R6 cons_valid", 64'(cons_valid), 64'(e_putc));
    if (e_putc) chk("R6 cons_byte", 64'(cons_byte), 64'(e_byte));
    chk("R8 unsup_err", 64'(unsup_err), 64'(m_err));
  endtask

  function automatic logic [31:0] pick_hi();
    logic [7:0] dv, cm;
    case ($urandom % 4)
      0: dv = 8'd0; 1: dv = 8'd1; 2: dv = 8'd2; default: dv = 8'hFF;
    endcase
    cm = 8'($urandom % 3);
    return {dv, cm, 16'($urandom)};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd17));
    rst_n = 1'b0; bus_we = 1'b0; bus_word = 2'd0; bus_wdata = '0;
    m_out = '0; m_ret = '0; m_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 off", 64'(off_pulse), 64'd0);
    chk("R1 cons", 64'(cons_valid), 64'd0);
    chk("R1 err", 64'(unsup_err), 64'd0);
    rd_all("R1 words");

    // R3 low write alone
    wr(2'd0, 32'h1234_00AB);
    rd_all("R3 readback");
    // R2 return register plain storage
    wr(2'd2, 32'hCAFE_0001);
    wr(2'd3, 32'h0BAD_F00D);
    rd_all("R2 readback");

    // R6 console put, then R9 pulse lasts one cycle
    wr(2'd0, 32'h0000_0041);
    wr(2'd1, 32'h0101_0000);
    rd_all("R6 regs");
    @(negedge clk);
    chk("R9 cons single", 64'(cons_valid), 64'd0);

    // R7 drop
    wr(2'd2, 32'h5555_AAAA);
    wr(2'd0, 32'h0000_0005);
    wr(2'd1, 32'h0100_7777);
    rd_all("R7 regs");

    // R5 exact one
    wr(2'd0, 32'h0000_0001);
    wr(2'd1, 32'h0000_0000);
    rd_all("R5 regs");
    @(negedge clk);
    chk("R9 off single", 64'(off_pulse), 64'd0);

    // R4 near miss: device 0 with low word 2 is unsupported
    wr(2'd0, 32'h0000_0002);
    wr(2'd1, 32'h0000_0000);
    rd_all("R4 regs");
    // R8 unsupported device, then sticky across a good command
    wr(2'd1, 32'h0201_0000);
    rd_all("R8 regs");
    wr(2'd1, 32'h0101_0000);

    // random mix
    for (int k = 0; k < 150; k++) begin
      int op;
      op = int'($urandom % 6);
      if (op == 0) begin
        wr(2'd0, 32'd1); wr(2'd1, 32'd0);
      end else if (op < 3) wr(2'd1, pick_hi());
      else wr(2'($urandom % 4), $urandom);
      rd_all("R2 random");
    end

    // R8 flag clears only on reset
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    m_out = '0; m_ret = '0; m_err = 0;
    chk("R8 err reset", 64'(unsup_err), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    rd_all("R1 after reset");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule